// File: doc/BRIEF.md
# Constant-Time GF(2^m) Multiply-Divide Unit

This block evaluates the single expression a·b/c over a binary extension field GF(2^m). The field degree m and the reduction polynomial are supplied with each operation, so one compiled instance serves every degree from 2 up to a compiled maximum `M`. Multiplication, inversion, squaring and division need no separate modes. They are all obtained by choosing the operands:

- multiply: set c = 1
- invert: set a = b = 1
- square: set a = b
- divide a by c: set b = 1

Each operation takes a fixed number of cycles that depends only on m, never on the operand values. One cycle latches the inputs. One cycle forms the product a·b reduced modulo the field polynomial. The divisor c is then removed by a binary extended-Euclid reduction of exactly 2m steps. The reduction ends with a result register and a one-cycle `done` pulse. A divisor of zero yields a zero result together with an error flag, with the timing unchanged.

Top module: `gfMulDiv`

## Requirements
- R1: For c ≠ 0, `result` equals a·b·c⁻¹ in GF(2)[x] modulo the field polynomial, where bit i of every operand and of `result` is the coefficient of xⁱ.
- R2: With c = 1, `result` is the field product a·b.
- R3: With a = b = 1, `result` is the multiplicative inverse of c.
- R4: With a = b, `result` is a²; with b = 1, `result` is a/c.
- R5: The degree m is taken from `degree` (2 ≤ m ≤ M). The field polynomial is `fieldPoly` with bit m set. Bits of `fieldPoly` above m, and operand bits at or above m, are ignored.
- R6: `done` rises exactly 2m+2 clock cycles after the cycle in which `start` is accepted, whatever the operand values.
- R7: `busy` is high from the cycle after acceptance until `done`, and low in the `done` cycle. `done` lasts exactly one cycle.
- R8: `start` is ignored while `busy` is high. Operand, polynomial and degree inputs are sampled only in the accepting cycle, so later changes do not alter the result.
- R9: If c = 0 (after masking), `result` is 0 and `divZero` is 1 in the `done` cycle. Otherwise `divZero` is 0.
- R10: After reset, `busy`, `done`, `divZero` and `result` are all 0.
- R11: `result` is fully reduced: every bit at or above position m is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an operation; accepted when `busy` is low |
| degree | input | $clog2(M+1) | Field degree m |
| fieldPoly | input | M+1 | Reduction polynomial, bit m set |
| opA | input | M | First factor a |
| opB | input | M | Second factor b |
| opC | input | M | Divisor c |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| divZero | output | 1 | Divisor was zero for the finished operation |
| result | output | M | a·b/c, reduced to m bits |

## Verification
The bench targets the smallest field (m = 2) and the compiled maximum (m = M):
- An off-by-one in the runtime top-bit selection shows up at these degrees as wrong reductions or as bits left set above m.
- Operands and polynomials carrying junk above bit m are fed in. A unit that failed to mask them would return products from the wrong field.

Other corner cases:
- A zero divisor must give 0 with the flag at the normal latency. A design that skipped this would return a garbage power of x, or finish early.
- Extra start pulses and changing inputs during an operation would, if accepted, produce a second `done` or a corrupted result.
- Every result is also timed against 2m+2 cycles, so a loop count that depended on the data would show up as a latency mismatch.

// File: rtl/gfmd_pkg.sv
package gfmd_pkg;

  // Strobes from the sequencer to the datapath, one-hot or idle.
  typedef struct packed {
    logic capture;  // latch raw inputs
    logic load;     // seed the reduction registers
    logic step;     // perform one reduction step
    logic finish;   // register the result
  } gfmdStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_FIN  = 2'd3
  } gfmdState_t;

endpackage

// File: rtl/gfmdMulComb.sv
// Combinational a*b mod f with a runtime degree, MSB-first Horner chain.
module gfmdMulComb #(
  parameter int M = 16
) (
  input  logic [M:0]   poly,     // masked field polynomial
  input  logic [M:0]   topSel,   // one-hot at bit m
  input  logic [M-1:0] mulA,     // masked, bits >= m are zero
  input  logic [M-1:0] mulB,     // masked, bits >= m are zero
  output logic [M:0]   product   // < x^m
);

  logic [M:0] acc [0:M];

  assign acc[0] = '0;

  for (genvar i = 0; i < M; i++) begin : g_stage
    logic [M:0] shifted;
    logic [M:0] reduced;
    assign shifted = {acc[i][M-1:0], 1'b0};
    assign reduced = (|(shifted & topSel)) ? (shifted ^ poly) : shifted;
    assign acc[i+1] = mulA[M-1-i] ? (reduced ^ {1'b0, mulB}) : reduced;
  end

  assign product = acc[M];

endmodule

// File: rtl/gfmdCtrl.sv
// Sequencer: accept, load, 2m reduction steps, finish.
module gfmdCtrl
  import gfmd_pkg::*;
#(
  parameter int M     = 16,
  parameter int DEG_W = $clog2(M + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DEG_W-1:0] degreeIn,
  output gfmdStrobes_t     stb,
  output logic             busy,
  output logic             done
);

  localparam int CW = DEG_W + 1;
  localparam int EW = DEG_W + 2;

  gfmdState_t       stateQ;
  logic [DEG_W-1:0] mQ;
  logic [CW-1:0]    cntQ;
  logic             doneQ;
  logic             accept;

  assign accept = start && (stateQ == ST_IDLE);
  assign busy   = (stateQ != ST_IDLE);
  assign done   = doneQ;

  always_comb begin
    stb         = '0;
    stb.capture = accept;
    stb.load    = (stateQ == ST_LOAD);
    stb.step    = (stateQ == ST_RUN);
    stb.finish  = (stateQ == ST_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      mQ     <= '0;
      cntQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= (stateQ == ST_FIN);
      unique case (stateQ)
        ST_IDLE: begin
          if (start) begin
            mQ     <= degreeIn;
            stateQ <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          cntQ   <= {mQ, 1'b0} - CW'(1);
          stateQ <= ST_RUN;
        end
        ST_RUN: begin
          if (cntQ == '0) stateQ <= ST_FIN;
          else            cntQ   <= cntQ - CW'(1);
        end
        ST_FIN: stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // Checker-only cycle counter since the last accepted start.
  logic [EW-1:0] elapsedQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                elapsedQ <= '0;
    else if (accept)          elapsedQ <= '0;
    else if (~&elapsedQ)      elapsedQ <= elapsedQ + EW'(1);
  end

  // R6
  latency_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (elapsedQ == ({1'b0, mQ, 1'b0} + EW'(2))));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  idle_at_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (mQ == $past(mQ)));

endmodule

// File: rtl/gfmdDatapath.sv
// Operand capture, product seed and constant-time binary Euclid divider.
module gfmdDatapath
  import gfmd_pkg::*;
#(
  parameter int M     = 16,
  parameter int DEG_W = $clog2(M + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  gfmdStrobes_t     stb,
  input  logic [DEG_W-1:0] degreeIn,
  input  logic [M:0]       polyIn,
  input  logic [M-1:0]     aIn,
  input  logic [M-1:0]     bIn,
  input  logic [M-1:0]     cIn,
  output logic [M-1:0]     result,
  output logic             divZero
);

  localparam int DW = DEG_W + 1;

  // Captured inputs
  logic [M-1:0]     aQ, bQ, cQ;
  logic [M:0]       polyQ;
  logic [DEG_W-1:0] mQ;

  // Reduction state
  logic [M:0]    regR, regS, regU, regV;
  logic [DW-1:0] deltaQ;
  logic          zeroQ;
  logic [M-1:0]  resultQ;
  logic          divZeroQ;

  // Derived masks for the runtime degree
  logic [M:0] topSel, lowMask, polyEff;
  logic [M:0] aMask, bMask, cMask;
  logic [M:0] prod;

  always_comb begin
    topSel  = (M+1)'(1) << mQ;
    lowMask = topSel - (M+1)'(1);
    polyEff = polyQ & (topSel | lowMask);
    aMask   = {1'b0, aQ} & lowMask;
    bMask   = {1'b0, bQ} & lowMask;
    cMask   = {1'b0, cQ} & lowMask;
  end

  gfmdMulComb #(.M(M)) u_mul (
    .poly    (polyEff),
    .topSel  (topSel),
    .mulA    (aMask[M-1:0]),
    .mulB    (bMask[M-1:0]),
    .product (prod)
  );

  function automatic logic [M:0] timesX(input logic [M:0] v,
                                        input logic [M:0] sel,
                                        input logic [M:0] f);
    logic [M:0] sh;
    sh = {v[M-1:0], 1'b0};
    return (|(sh & sel)) ? (sh ^ f) : sh;
  endfunction

  function automatic logic [M:0] overX(input logic [M:0] v,
                                       input logic [M:0] f);
    logic [M:0] t;
    t = v[0] ? (v ^ f) : v;
    return {1'b0, t[M:1]};
  endfunction

  // One reduction step
  logic [M:0]    nR, nS, nU, nV;
  logic [DW-1:0] nDelta;
  logic          rTop, sTop;
  logic [M:0]    sSub, vSub;

  always_comb begin
    rTop   = |(regR & topSel);
    sTop   = |(regS & topSel);
    sSub   = sTop ? (regS ^ regR) : regS;
    vSub   = sTop ? (regV ^ regU) : regV;
    nR     = regR;
    nS     = regS;
    nU     = regU;
    nV     = regV;
    nDelta = deltaQ;
    if (!rTop) begin
      nR     = {regR[M-1:0], 1'b0};
      nU     = timesX(regU, topSel, polyEff);
      nDelta = deltaQ + DW'(1);
    end else if (deltaQ == '0) begin
      nR     = {sSub[M-1:0], 1'b0};
      nS     = regR;
      nU     = timesX(vSub, topSel, polyEff);
      nV     = regU;
      nDelta = DW'(1);
    end else begin
      nS     = {sSub[M-1:0], 1'b0};
      nV     = vSub;
      nU     = overX(regU, polyEff);
      nDelta = deltaQ - DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aQ       <= '0;
      bQ       <= '0;
      cQ       <= '0;
      polyQ    <= '0;
      mQ       <= '0;
      regR     <= '0;
      regS     <= '0;
      regU     <= '0;
      regV     <= '0;
      deltaQ   <= '0;
      zeroQ    <= 1'b0;
      resultQ  <= '0;
      divZeroQ <= 1'b0;
    end else begin
      if (stb.capture) begin
        aQ    <= aIn;
        bQ    <= bIn;
        cQ    <= cIn;
        polyQ <= polyIn;
        mQ    <= degreeIn;
      end
      if (stb.load) begin
        regR   <= cMask;
        regS   <= polyEff;
        regU   <= prod;
        regV   <= '0;
        deltaQ <= '0;
        zeroQ  <= (cMask == '0);
      end
      if (stb.step) begin
        regR   <= nR;
        regS   <= nS;
        regU   <= nU;
        regV   <= nV;
        deltaQ <= nDelta;
      end
      if (stb.finish) begin
        resultQ  <= zeroQ ? '0 : regU[M-1:0];
        divZeroQ <= zeroQ;
      end
    end
  end

  assign result  = resultQ;
  assign divZero = divZeroQ;

  // R11
  result_reduced_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> ((resultQ & ~lowMask[M-1:0]) == '0));

  // R9
  zero_div_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> (!divZeroQ || (resultQ == '0)));

  // R1
  seed_reduced_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> ((regU & ~lowMask) == '0));

endmodule

// File: rtl/gfMulDiv.sv
// Top: a*b/c over GF(2^m), runtime m and polynomial, 2m+2 cycle latency.
module gfMulDiv
  import gfmd_pkg::*;
#(
  parameter int M     = 16,
  parameter int DEG_W = $clog2(M + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DEG_W-1:0] degree,
  input  logic [M:0]       fieldPoly,
  input  logic [M-1:0]     opA,
  input  logic [M-1:0]     opB,
  input  logic [M-1:0]     opC,
  output logic             busy,
  output logic             done,
  output logic             divZero,
  output logic [M-1:0]     result
);

  gfmdStrobes_t stb;

  gfmdCtrl #(.M(M), .DEG_W(DEG_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .degreeIn (degree),
    .stb      (stb),
    .busy     (busy),
    .done     (done)
  );

  gfmdDatapath #(.M(M), .DEG_W(DEG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .degreeIn (degree),
    .polyIn   (fieldPoly),
    .aIn      (opA),
    .bIn      (opB),
    .cIn      (opC),
    .result   (result),
    .divZero  (divZero)
  );

  // R9
  flag_with_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && divZero) |-> (result == '0));

endmodule

// File: tb/gfMulDiv_tb.sv
`timescale 1ns/1ps
module gfMulDiv_tb;

  localparam int M     = 16;
  localparam int DEG_W = $clog2(M + 1);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [DEG_W-1:0] degree = '0;
  logic [M:0]       fieldPoly = '0;
  logic [M-1:0]     opA = '0, opB = '0, opC = '0;
  logic             busy, done, divZero;
  logic [M-1:0]     result;

  gfMulDiv #(.M(M), .DEG_W(DEG_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .degree(degree),
    .fieldPoly(fieldPoly), .opA(opA), .opB(opB), .opC(opC),
    .busy(busy), .done(done), .divZero(divZero), .result(result)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFail   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference field arithmetic
  function automatic logic [M-1:0] rMul(input logic [M-1:0] x, input logic [M-1:0] y,
                                        input logic [M:0] f, input int m);
    logic [M:0] p;
    p = '0;
    for (int i = m - 1; i >= 0; i--) begin
      p = p << 1;
      if (p[m]) p = p ^ f;
      if (x[i]) p = p ^ {1'b0, y};
    end
    return p[M-1:0];
  endfunction

  function automatic logic [M-1:0] rInv(input logic [M-1:0] c, input logic [M:0] f,
                                        input int m);
    logic [M-1:0] acc, base;
    longint e;
    acc  = 1;
    base = c;
    e    = (longint'(1) << m) - 2;
    while (e != 0) begin
      if (e[0]) acc = rMul(acc, base, f, m);
      base = rMul(base, base, f, m);
      e    = e >> 1;
    end
    return acc;
  endfunction

  typedef struct {
    logic [M-1:0] res;
    logic         err;
    int           due;
    int           m;
    string        tag;
  } item_t;
  item_t sbq[$];

  // Monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R8", "unexpected done", 1, 0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(result == it.res, it.tag, "result", result, it.res);
        check(divZero == it.err, "R9", "divZero", divZero, it.err);
        check(cyc == it.due, "R6", "done cycle", cyc, it.due);
        check((result >> it.m) == 0, "R11", "bits above m", result, 0);
        check(!busy, "R7", "busy at done", busy, 0);
      end
    end
  end

  task automatic runOp(input logic [M-1:0] a, input logic [M-1:0] b,
                       input logic [M-1:0] c, input logic [M:0] f,
                       input int m, input string tag);
    item_t it;
    logic [M-1:0] msk, am, bm, cm;
    logic [M:0]   fm;
    @(negedge clk);
    while (busy) @(negedge clk);
    msk = M'((longint'(1) << m) - 1);
    am  = a & msk;
    bm  = b & msk;
    cm  = c & msk;
    fm  = f & (M+1)'((longint'(1) << (m + 1)) - 1);
    it.err = (cm == 0);
    it.res = it.err ? '0 : rMul(rMul(am, bm, fm, m), rInv(cm, fm, m), fm, m);
    it.due = cyc + 1 + 2 * m + 2;
    it.m   = m;
    it.tag = tag;
    sbq.push_back(it);
    opA = a; opB = b; opC = c; fieldPoly = f; degree = DEG_W'(m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7", "busy after accept", busy, 1);
  endtask

  int fldM[5] = '{2, 3, 4, 8, 16};
  int fldP[5] = '{'h7, 'hB, 'h13, 'h11B, 'h1100B};
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(busy == 0, "R10", "busy", busy, 0);
    check(done == 0, "R10", "done", done, 0);
    check(divZero == 0, "R10", "divZero", divZero, 0);
    check(result == 0, "R10", "result", result, 0);

    runOp(1, 1, 2, 'h7, 2, "R3");             // inverse of x, smallest field
    runOp('h7, 'h9, 1, 'h13, 4, "R2");        // multiply
    runOp('h53, 'hCA, 1, 'h11B, 8, "R2");     // multiply of an inverse pair
    runOp(1, 1, 'h53, 'h11B, 8, "R3");        // inverse
    runOp('h80, 'h80, 1, 'h11B, 8, "R4");     // square
    runOp('h57, 1, 'h83, 'h11B, 8, "R4");     // divide
    runOp(1, 1, 'hFFFF, 'h1100B, 16, "R3");   // widest field inverse
    runOp('hFFFF, 'hFFFF, 1, 'h1100B, 16, "R4");
    runOp('h1234, 'hABCD, 'h0F0F, 'h1100B, 16, "R1");
    runOp('hFFF7, 'hFFF9, 'hFFF1, 'h1FF13, 4, "R5"); // junk above m
    runOp('h3, 'h2, 'h10, 'h1FF13, 4, "R5");  // c masks to zero
    runOp('h5, 'h6, 0, 'h11B, 8, "R9");       // zero divisor
    runOp('h3, 'h3, 0, 'h7, 2, "R9");

    for (int k = 0; k < 30; k++) begin
      int fi;
      logic [M-1:0] a, b, c;
      rng = nextRand(rng); fi = int'(rng % 5);
      rng = nextRand(rng); a = rng[M-1:0];
      rng = nextRand(rng); b = rng[M-1:0];
      rng = nextRand(rng); c = rng[M-1:0];
      runOp(a, b, c, (M+1)'(fldP[fi]), fldM[fi], "R1");
    end

    // R8: extra starts and changing inputs while busy
    runOp('h1F, 'h2C, 'h3D, 'h11B, 8, "R8");
    for (int k = 0; k < 4; k++) begin
      opA = M'(k * 7 + 1); opB = M'(k + 3); opC = 0;
      fieldPoly = 'h13; degree = DEG_W'(4);
      start = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;

    @(negedge clk);
    while (busy || sbq.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    check(sbq.size() == 0, "R8", "pending results", sbq.size(), 0);
    finishRun();
  end

endmodule